// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one external interrupt request pin. It turns qualified events on that pin into a sticky event flag and an interrupt request to the processor. Software uses one 8-bit status and control register to do five things: switch the pin function on, pick the active polarity, pick edge-only or edge-plus-level sensitivity, enable the interrupt request and acknowledge events. The same register also controls the enable for the pin's internal pull device. The active polarity decides whether that device pulls up or pulls down.

The raw pin passes through a two-stage synchronizer. An edge is detected by comparing the synchronized sample with the sample taken one clock earlier. The register is accessed through a simple synchronous port: a write strobe with write data, and a read data bus that is refreshed from the register state on every clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, `irq_o` is 0, and `pull_en_o` and `pull_down_o` are 0.
- R2: Read data is registered one clock after the state. Bit 7 and bit 2 always read 0. Bit 3 reads the event flag. Bits 6 (pull disable), 5 (polarity), 4 (pin enable), 1 (interrupt enable) and 0 (mode) read back the last written values.
- R3: When bit 4 is 0, no pin activity sets the flag.
- R4: Polarity bit 5 = 0 makes falling edges and low levels active. Bit 5 = 1 makes rising edges and high levels active. Edges of the other direction are ignored.
- R5: With mode bit 0 = 0, the flag is set only by an active edge. An active level that persists after an acknowledge does not set it again.
- R6: With mode bit 0 = 1, the flag is set by an active edge or an active level. The flag cannot be cleared while the synchronized pin remains at the active level.
- R7: Writing 1 to bit 2 clears the flag unless an event is being set in the same cycle. Writing 0 to bit 2 leaves the flag unchanged.
- R8: If a new qualifying event and an acknowledge write occur in the same cycle, the flag stays set.
- R9: `irq_o` is high exactly when the flag and the interrupt enable bit 1 are both set.
- R10: `pull_en_o` is high when bit 4 = 1 and bit 6 = 0. `pull_down_o` follows bit 5. Both are registered one clock after the register.
- R11: A pin change reaches the flag on the third rising clock edge after the pin changes: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw external interrupt request pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered register read data |
| irq_o | output | 1 | Interrupt request to the processor |
| pull_en_o | output | 1 | Internal pull device enable |
| pull_down_o | output | 1 | 1 selects pull-down, 0 selects pull-up |

## Verification
The bench aims an acknowledge write at the exact clock in which a new edge qualifies. A design that lets the clear win would silently lose that event. In level mode it acknowledges while the pin is still active and expects the flag to survive; a design that clears anyway would drop a pending level request. It also writes acknowledge as 0, toggles the pin while the function is disabled, and drives edges of the wrong polarity. A design that reacted to any of these would show a stray flag or interrupt. Finally, it counts clock edges from a pin change to the interrupt, which exposes a missing or extra synchronizer stage.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 8;
  localparam int B_PDD   = 6;
  localparam int B_POL   = 5;
  localparam int B_PE    = 4;
  localparam int B_FLAG  = 3;
  localparam int B_ACK   = 2;
  localparam int B_IE    = 1;
  localparam int B_MODE  = 0;

  typedef struct packed {
    logic pdd;
    logic pol;
    logic pe;
    logic ie;
    logic mode;
  } ctrl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect (
  input  logic clk,
  input  logic rst,
  input  logic sync_q,
  input  logic pe,
  input  logic pol,
  input  logic mode,
  output logic set_evt,
  output logic lvl_active
);
  logic prev_q;
  logic edge_evt;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q;
  end

  always_comb begin
    lvl_active = (sync_q == pol);
    edge_evt   = (sync_q != prev_q) && lvl_active;
    set_evt    = pe && (edge_evt || (mode && lvl_active));
  end

  // R4
  wrong_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && (sync_q != pol)) |-> !set_evt);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          set_evt,
  input  logic          lvl_active,
  output ctrl_t         ctrl,
  output logic [DW-1:0] rd_data,
  output logic          irq_o,
  output logic          pull_en_o,
  output logic          pull_down_o
);
  logic flag_q;
  logic ack;
  logic unused_wr;

  assign ack       = wr_en && wr_data[B_ACK];
  assign unused_wr = ^{wr_data[DW-1], wr_data[B_FLAG]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.pdd  <= wr_data[B_PDD];
      ctrl.pol  <= wr_data[B_POL];
      ctrl.pe   <= wr_data[B_PE];
      ctrl.ie   <= wr_data[B_IE];
      ctrl.mode <= wr_data[B_MODE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (ack)     flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      pull_en_o   <= 1'b0;
      pull_down_o <= 1'b0;
    end else begin
      rd_data         <= '0;
      rd_data[B_PDD]  <= ctrl.pdd;
      rd_data[B_POL]  <= ctrl.pol;
      rd_data[B_PE]   <= ctrl.pe;
      rd_data[B_FLAG] <= flag_q;
      rd_data[B_IE]   <= ctrl.ie;
      rd_data[B_MODE] <= ctrl.mode;
      pull_en_o       <= ctrl.pe && !ctrl.pdd;
      pull_down_o     <= ctrl.pol;
    end
  end

  assign irq_o = flag_q && ctrl.ie;

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_evt) |=> !flag_q);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q);
  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pe && ctrl.mode && lvl_active) |=> flag_q);
  // R3
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pe && !flag_q) |=> !flag_q);
  // R10
  pull_chk: assert property (@(posedge clk) disable iff (rst)
    pull_en_o |-> ($past(ctrl.pe) && !$past(ctrl.pdd)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_in,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq_o,
  output logic          pull_en_o,
  output logic          pull_down_o
);
  logic  pin_s;
  logic  set_evt;
  logic  lvl_active;
  ctrl_t ctrl;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_in),
    .q_out (pin_s)
  );

  irq_detect u_det (
    .clk        (clk),
    .rst        (rst),
    .sync_q     (pin_s),
    .pe         (ctrl.pe),
    .pol        (ctrl.pol),
    .mode       (ctrl.mode),
    .set_evt    (set_evt),
    .lvl_active (lvl_active)
  );

  irq_regs #(.DW(DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .set_evt     (set_evt),
    .lvl_active  (lvl_active),
    .ctrl        (ctrl),
    .rd_data     (rd_data),
    .irq_o       (irq_o),
    .pull_en_o   (pull_en_o),
    .pull_down_o (pull_down_o)
  );
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_in = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_o, pull_en_o, pull_down_o;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o), .pull_en_o(pull_en_o), .pull_down_o(pull_down_o)
  );

  // {wr, wdata, pin, exp_rd, exp_irq, exp_pull_en, exp_pull_down}
  // bits: 6 pull disable, 5 polarity, 4 pin enable, 3 flag, 2 ack, 1 irq enable, 0 mode
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h12, 1'b1, 8'h12, 3'b010}, // R2 R10 enable, falling polarity
    {1'b0, 8'h00, 1'b0, 8'h1A, 3'b110}, // R4 R9 falling edge
    {1'b1, 8'h16, 1'b0, 8'h12, 3'b010}, // R5 R7 ack while low, edge mode
    {1'b0, 8'h00, 1'b1, 8'h12, 3'b010}, // R4 rising edge ignored
    {1'b1, 8'h13, 1'b1, 8'h13, 3'b010}, // R2 level mode
    {1'b0, 8'h00, 1'b0, 8'h1B, 3'b110}, // R6 falling edge
    {1'b1, 8'h17, 1'b0, 8'h1B, 3'b110}, // R6 ack blocked at low level
    {1'b0, 8'h00, 1'b1, 8'h1B, 3'b110}, // R6 flag sticky after level leaves
    {1'b1, 8'h13, 1'b1, 8'h1B, 3'b110}, // R7 ack written as 0
    {1'b1, 8'h17, 1'b1, 8'h13, 3'b010}, // R7 ack clears
    {1'b1, 8'h31, 1'b1, 8'h39, 3'b011}, // R4 R6 R9 R10 high level active, ie off
    {1'b1, 8'h75, 1'b0, 8'h79, 3'b001}, // R6 R10 ack while level still seen
    {1'b1, 8'h74, 1'b0, 8'h70, 3'b001}, // R7 clear in edge mode
    {1'b1, 8'h20, 1'b1, 8'h20, 3'b001}, // R3 disabled, rising ignored
    {1'b1, 8'h84, 1'b0, 8'h00, 3'b000}, // R2 bits 7 and 2 read 0
    {1'b1, 8'h32, 1'b0, 8'h32, 3'b011}, // R4 rising polarity, edge mode
    {1'b0, 8'h00, 1'b1, 8'h3A, 3'b111}  // R4 R9 rising edge
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 pull", {6'd0, pull_en_o, pull_down_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      pin_in = v[11];
      if (v[20]) wr(v[19:12]);
      else @(negedge clk);
      repeat (4) @(negedge clk);
      chk($sformatf("vec %0d rd (R2 R3 R4 R5 R6 R7)", i), rd_data, v[10:3]);
      chk($sformatf("vec %0d irq (R9)", i), {7'd0, irq_o}, {7'd0, v[2]});
      chk($sformatf("vec %0d pull (R10)", i), {6'd0, pull_en_o, pull_down_o}, {6'd0, v[1:0]});
    end

    // R8: acknowledge lands in the same cycle as a new rising edge
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h36);
    repeat (3) @(negedge clk);
    chk("R8 set beats ack", rd_data, 8'h3A);
    chk("R8 irq", {7'd0, irq_o}, 8'h01);

    // R11: latency from pin change to interrupt
    wr(8'h36);
    repeat (3) @(negedge clk);
    chk("R7 cleared", rd_data, 8'h32);
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    pin_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 no irq after two edges", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    chk("R11 irq on third edge", {7'd0, irq_o}, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule